// File: doc/BRIEF.md
# Local Interrupt Controller Timer

A programmable down-counting timer for a per-core local interrupt controller. Software-side logic writes three things through dedicated write strobes: a start count, a divider selection, and a timer entry holding a mask flag, a mode flag (one-shot or periodic) and an 8-bit vector. The block exposes the live count and raises a single-cycle interrupt request that carries the entry's vector whenever the count expires.

A prescaler divides the input clock by a power of two chosen by the divider selection, and every prescaler tick advances the counter by one step. One expiry period lasts the start count plus one ticks: the count runs down to zero, and the tick after zero is the expiry. In periodic mode the counter then reloads and keeps running. In one-shot mode it stops at zero. A zero start count never produces an expiry in either mode. Masking suppresses the request but does not stop the counting.

Top module: `lic_timer`

## Requirements
- R1: After reset the count output reads 0, no request is raised, the entry is masked in one-shot mode with vector 0, and the divider selection is 3'b000, which means divide by 2.
- R2: The counter steps once every 2^s clock cycles. The 3-bit divider selection `div_sel_i` maps to s as follows: 3'b111 gives s=0, and any other value v gives s=v+1 (1 to 7).
- R3: Writing the start count loads it into the count output on the next cycle and restarts the prescaler phase, so the first step comes 2^s cycles after the write edge.
- R4: In one-shot mode (mode flag 0), c cycles after the load edge the count reads N - (c>>s), where N is the start count. Once c>>s reaches N it reads 0 and stays at 0.
- R5: In one-shot mode with N>0, exactly one request is raised, at c = (N+1)<<s, and none after it.
- R6: In periodic mode (mode flag 1) with N>0, the count reads N - ((c>>s) mod (N+1)), and a request is raised at every nonzero c that is a multiple of (N+1)<<s.
- R7: In periodic mode with N=0, the count reads 0 and no request is ever raised.
- R8: In one-shot mode, a start count of 0 leaves the count at 0 and raises no request.
- R9: While the mask flag is 1, no request is raised. The count still follows R4 or R6.
- R10: A request lasts exactly one cycle, and `irq_vector_o` equals the entry's 8-bit vector while `irq_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_we_i | input | 1 | Start-count write strobe |
| cnt_wdata_i | input | CNT_W | Start count |
| div_we_i | input | 1 | Divider selection write strobe |
| div_sel_i | input | 3 | Divider selection code |
| ent_we_i | input | 1 | Timer entry write strobe |
| ent_mask_i | input | 1 | Entry mask flag (1 = masked) |
| ent_periodic_i | input | 1 | Entry mode flag (1 = periodic) |
| ent_vector_i | input | VEC_W | Entry vector |
| cur_count_o | output | CNT_W | Live count |
| irq_valid_o | output | 1 | Single-cycle interrupt request |
| irq_vector_o | output | VEC_W | Vector carried with the request |

## Verification
The assertions assume that each write strobe is a clean single-bit level sampled at the clock edge. They also assume the counter is never asked to step below zero, because a nonzero count only decrements. The bench programs the entry and the divider before each start-count write and leaves them unchanged while a run is observed. This keeps each run under one fixed mode, mask and divider, so the closed-form expected count and request times apply.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned PRESC_W = (1 << SHIFT_W) - 1;

  // 3'b111 selects divide-by-1, every other code v selects 2^(v+1)
  function automatic logic [SHIFT_W-1:0] sel_to_shift(input logic [2:0] sel);
    return (sel == 3'b111) ? '0 : SHIFT_W'(sel + 3'd1);
  endfunction
endpackage

// File: rtl/lic_timer_prescaler.sv
module lic_timer_prescaler
  import lic_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] phase_q;
  logic [PRESC_W-1:0] low_mask;

  assign low_mask = (PRESC_W'(1) << shift_i) - PRESC_W'(1);
  assign tick_o   = (phase_q & low_mask) == low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else            phase_q <= phase_q + PRESC_W'(1);
  end

  // R3
  phase_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o || shift_i == '0);
endmodule

// File: rtl/lic_timer_counter.sv
module lic_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             masked_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, init_q;
  logic             run_q, fire_q;
  logic             expire;

  assign expire  = tick_i && !load_i && cnt_q == '0 && run_q;
  assign count_o = cnt_q;
  assign fire_o  = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load_i) begin
        cnt_q  <= load_val_i;
        init_q <= load_val_i;
        run_q  <= load_val_i != '0;
      end else if (tick_i) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (run_q) begin
          fire_q <= !masked_i;
          if (periodic_i) cnt_q <= init_q;
          else            run_q <= 1'b0;
        end
      end
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  // R2
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  // R4
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !periodic_i) |=> !run_q && cnt_q == '0);
  // R7
  zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> !run_q);
endmodule

// File: rtl/lic_timer.sv
module lic_timer
  import lic_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             div_we_i,
  input  logic [2:0]       div_sel_i,
  input  logic             ent_we_i,
  input  logic             ent_mask_i,
  input  logic             ent_periodic_i,
  input  logic [VEC_W-1:0] ent_vector_i,
  output logic [CNT_W-1:0] cur_count_o,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vector_o
);
  logic             mask_q, periodic_q;
  logic [VEC_W-1:0] vector_q;
  logic [2:0]       div_q;
  logic [SHIFT_W-1:0] shift;
  logic             tick, fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= 1'b1;
      periodic_q <= 1'b0;
      vector_q   <= '0;
      div_q      <= 3'b000;
    end else begin
      if (ent_we_i) begin
        mask_q     <= ent_mask_i;
        periodic_q <= ent_periodic_i;
        vector_q   <= ent_vector_i;
      end
      if (div_we_i) div_q <= div_sel_i;
    end
  end

  assign shift = sel_to_shift(div_q);

  lic_timer_prescaler u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_we_i),
    .shift_i (shift),
    .tick_o  (tick)
  );

  lic_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_wdata_i),
    .tick_i     (tick),
    .periodic_i (periodic_q),
    .masked_i   (mask_q),
    .count_o    (cur_count_o),
    .fire_o     (fire)
  );

  // vector is captured with the request so a later entry write cannot alter it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        irq_vector_o <= '0;
    else if (tick && cur_count_o == '0) irq_vector_o <= vector_q;
  end

  assign irq_valid_o = fire;

  // R9
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> !$past(mask_q));
  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |=> !irq_valid_o);
  // R10
  vector_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_vector_o == $past(vector_q));
endmodule

// File: tb/lic_timer_tb.sv
module lic_timer_tb;
  localparam int CNT_W = 32;
  localparam int VEC_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cnt_we_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic             div_we_i = 1'b0;
  logic [2:0]       div_sel_i = '0;
  logic             ent_we_i = 1'b0;
  logic             ent_mask_i = 1'b0;
  logic             ent_periodic_i = 1'b0;
  logic [VEC_W-1:0] ent_vector_i = '0;
  logic [CNT_W-1:0] cur_count_o;
  logic             irq_valid_o;
  logic [VEC_W-1:0] irq_vector_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lic_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .div_we_i(div_we_i), .div_sel_i(div_sel_i),
    .ent_we_i(ent_we_i), .ent_mask_i(ent_mask_i),
    .ent_periodic_i(ent_periodic_i), .ent_vector_i(ent_vector_i),
    .cur_count_o(cur_count_o), .irq_valid_o(irq_valid_o),
    .irq_vector_o(irq_vector_o)
  );

  function automatic int shift_of(input logic [2:0] sel);
    return (sel == 3'b111) ? 0 : int'(sel) + 1;
  endfunction

  function automatic longint exp_count(input bit per, input longint n, input int s, input longint c);
    longint t = c >> s;
    if (per) return (n == 0) ? 0 : n - (t % (n + 1));
    return (t >= n) ? 0 : n - t;
  endfunction

  function automatic bit exp_irq(input bit per, input bit msk, input longint n, input int s, input longint c);
    longint p = (n + 1) << s;
    if (msk || c == 0 || n == 0) return 1'b0;
    if (per) return (c % p) == 0;
    return c == p;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // tags: R2 divider, R3 load, R4/R5 one-shot, R6/R7 periodic, R8 zero, R9 mask, R10 pulse
  task automatic run_case(input bit per, input bit msk, input bit wr_div,
                          input logic [2:0] sel, input int n,
                          input logic [7:0] vec, input int ncyc);
    int s = wr_div ? shift_of(sel) : 1;
    string tag;
    tag = msk ? "R9" : (n == 0 ? (per ? "R7" : "R8") : (per ? "R6" : "R4"));
    @(negedge clk);
    ent_we_i = 1'b1; ent_mask_i = msk; ent_periodic_i = per; ent_vector_i = vec;
    @(negedge clk);
    ent_we_i = 1'b0;
    if (wr_div) begin
      div_we_i = 1'b1; div_sel_i = sel;
      @(negedge clk);
      div_we_i = 1'b0;
    end
    cnt_we_i = 1'b1; cnt_wdata_i = n;
    for (int c = 0; c <= ncyc; c++) begin
      @(negedge clk);
      cnt_we_i = 1'b0;
      if (c == 0) check("R3", cur_count_o, n);
      else        check({tag, "/R2 count"}, cur_count_o, exp_count(per, n, s, c));
      check(per ? "R6 irq" : "R5 irq", irq_valid_o, exp_irq(per, msk, n, s, c));
      if (irq_valid_o) check("R10 vector", irq_vector_o, vec);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a_5e71));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 count", cur_count_o, 0);
    check("R1 irq", irq_valid_o, 0);
    // R1: default divider is /2 with no divider write
    run_case(1'b0, 1'b0, 1'b0, 3'b000, 3, 8'h31, 14);
    // R8 one-shot zero, R7 periodic zero
    run_case(1'b0, 1'b0, 1'b1, 3'b111, 0, 8'h40, 12);
    run_case(1'b1, 1'b0, 1'b1, 3'b111, 0, 8'h41, 12);
    // R6 shortest period, divide by 1
    run_case(1'b1, 1'b0, 1'b1, 3'b111, 1, 8'hA5, 12);
    // R9 masked periodic keeps counting
    run_case(1'b1, 1'b1, 1'b1, 3'b000, 2, 8'h77, 30);
    // R2 largest divider
    run_case(1'b0, 1'b0, 1'b1, 3'b110, 1, 8'hFE, 3 * 256 + 4);
    // R5 one-shot well past expiry
    run_case(1'b0, 1'b0, 1'b1, 3'b001, 4, 8'h12, 80);
    for (int i = 0; i < 24; i++) begin
      bit per = $urandom_range(1, 0) == 1;
      bit msk = $urandom_range(3, 0) == 0;
      logic [2:0] sel = 3'($urandom_range(7, 0));
      int n = $urandom_range(12, 0);
      int span = (3 * (n + 1)) << shift_of(sel);
      if (span > 1200) span = 1200;
      run_case(per, msk, 1'b1, sel, n, 8'($urandom_range(255, 0)), span + 3);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule